// File: doc/BRIEF.md
# Capture Descriptor List Packer

This block turns a stream of capture requests into the compact descriptor list that a capture engine walks. Each request carries a 32-bit region base, a byte offset inside that region and a length in 32-bit words. The packer writes the list one word at a time into a descriptor SRAM of `SRAM_BYTES` bytes, starting at word 0 for every list. It signals the end of each list with a one-cycle pulse that carries the list length in words and three error flags.

Requests that stay on the same base and move forward share one base word. Their offsets are stored as deltas from the previous request, two offset/length pairs to a link word. A fresh base word is written only when the region changes or the offset steps backwards. The reported length is the index at which a capture engine would start storing payload. In the payload-checking mode, the list and the payload it will capture must fit in the SRAM together.

Top module: `desc_list_packer`

## Requirements
- R1: A base word, bit 31 set and bits 27:0 equal to base bits 31:4 (bits 30:28 zero), is written for the first entry of a list, for an entry whose base bits 31:4 differ from the previous entry, and for an entry whose word offset (byte offset / 4) is lower than the previous entry's.
- R2: Every entry with a nonzero length forms a 16-bit pair: offset delta in bits 7:0, length in bits 14:8, bit 15 zero. A link word holding one pair has that pair in bits 15:0 and 0x0001 in bits 31:16. The next pair replaces bits 31:16, and the word is then written.
- R3: A half-filled link word is written before any new base word. After a base word, the delta reference restarts from word offset 0.
- R4: At the end of a list, a half-filled link word is written, followed by an all-zero terminator word.
- R5: An offset delta above 255 or a length above 127 stops the list with `err_encode`. Nothing is written for that entry, and the reported length is 0.
- R6: A list that closes without any entry of nonzero length raises `err_empty`, writes nothing and reports length 0.
- R7: A write that would land at or beyond SRAM word `SRAM_BYTES/4` is not performed. It raises `err_overflow`, and the list reports length 0.
- R8: With `pay_mode` = 1, the list fails with `err_overflow` and length 0 when (list words + sum of entry lengths) × 4 exceeds `SRAM_BYTES`. With `pay_mode` = 0, only the list's own writes are bounded.
- R9: Each list ends with `done` high for exactly one cycle. On success, `list_words` equals the number of words written, terminator included.
- R10: A beat with length 0 and `ent_last` = 0 has no effect. A beat with length 0 and `ent_last` = 1 only closes the list.
- R11: After an error, the remaining beats up to and including the one with `ent_last` are accepted without any write. `done` follows the last of them.
- R12: Write addresses of a list run consecutively from 0, including for the first list after a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pay_mode | input | 1 | 1: check list plus captured payload against SRAM size |
| ent_valid | input | 1 | Entry beat valid |
| ent_ready | output | 1 | Packer accepts a beat this cycle |
| ent_last | input | 1 | Beat closes the list |
| ent_base | input | 32 | Region base address |
| ent_off | input | OFF_W | Byte offset from the base |
| ent_len | input | LEN_W | Length in words (0: no entry) |
| wr_en | output | 1 | SRAM write strobe |
| wr_addr | output | AW | SRAM word address |
| wr_data | output | 32 | Descriptor word |
| done | output | 1 | One-cycle end-of-list pulse |
| list_words | output | AW+1 | List length in words, 0 on failure |
| err_encode | output | 1 | Delta or length out of range |
| err_empty | output | 1 | List had no entries |
| err_overflow | output | 1 | SRAM capacity exceeded |

## Verification
The assertions assume that `pay_mode` stays constant from the first beat of a list to its `done`. They also assume that a beat's fields stay stable while `ent_valid` is high and the beat has not yet been accepted. The bench drives each beat on the falling edge and holds it until a rising edge that sees `ent_ready`. It changes `pay_mode` only between lists, once the previous `done` has been seen. It always closes a list with an `ent_last` beat before starting the next one.

// File: rtl/dlp_pkg.sv
package dlp_pkg;

  typedef enum logic [2:0] {
    S_ACC,    // take the next beat
    S_SEC,    // write the queued second word of a beat
    S_END,    // flush a pending link or write the terminator
    S_TERM,   // write the terminator after a flush
    S_DRAIN,  // discard beats after a failure
    S_FIN     // report the result
  } dlp_state_e;

  localparam logic [15:0] LINK_PRESET = 16'h0001;
  localparam int unsigned DELTA_MAX   = 255;
  localparam int unsigned LEN_MAX     = 127;

  function automatic logic [31:0] make_base_word(input logic [27:0] region);
    return {4'b1000, region};
  endfunction

endpackage

// File: rtl/dlp_pair_enc.sv
module dlp_pair_enc #(
  parameter int OFF_W = 16,
  parameter int LEN_W = 8,
  localparam int WOFF_W = OFF_W - 2
) (
  input  logic              first,
  input  logic [31:0]       base,
  input  logic [OFF_W-1:0]  off,
  input  logic [LEN_W-1:0]  len,
  input  logic [27:0]       prev_region,
  input  logic [WOFF_W-1:0] prev_woff,
  output logic              new_base,
  output logic [WOFF_W-1:0] woff,
  output logic [15:0]       pair,
  output logic              bad
);
  import dlp_pkg::*;

  logic [WOFF_W-1:0] ref_woff;
  logic [WOFF_W-1:0] delta;

  always_comb begin
    woff     = off[OFF_W-1:2];
    new_base = first || (base[31:4] != prev_region) || (woff < prev_woff);
    ref_woff = new_base ? '0 : prev_woff;
    delta    = woff - ref_woff;
    bad      = (delta > WOFF_W'(DELTA_MAX)) || (len > LEN_W'(LEN_MAX));
    pair     = {1'b0, len[6:0], delta[7:0]};
  end

endmodule

// File: rtl/dlp_cap_check.sv
module dlp_cap_check #(
  parameter int DEPTH = 64,
  parameter int SUM_W = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             pay_mode,
  input  logic [AW:0]      words,
  input  logic [SUM_W-1:0] payload,
  output logic             over
);
  logic [SUM_W:0] total;

  always_comb begin
    total = {1'b0, payload} + (SUM_W+1)'(words);
    over  = pay_mode && (total > (SUM_W+1)'(DEPTH));
  end

endmodule

// File: rtl/desc_list_packer.sv
module desc_list_packer #(
  parameter int SRAM_BYTES = 256,
  parameter int OFF_W      = 16,
  parameter int LEN_W      = 8,
  parameter int SUM_W      = 16,
  localparam int DEPTH  = SRAM_BYTES / 4,
  localparam int AW     = $clog2(DEPTH),
  localparam int WOFF_W = OFF_W - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pay_mode,
  input  logic             ent_valid,
  output logic             ent_ready,
  input  logic             ent_last,
  input  logic [31:0]      ent_base,
  input  logic [OFF_W-1:0] ent_off,
  input  logic [LEN_W-1:0] ent_len,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [31:0]      wr_data,
  output logic             done,
  output logic [AW:0]      list_words,
  output logic             err_encode,
  output logic             err_empty,
  output logic             err_overflow
);
  import dlp_pkg::*;

  // list state
  dlp_state_e        state_q, state_d;
  logic              first_q, first_d;
  logic [27:0]       region_q, region_d;
  logic [WOFF_W-1:0] woff_q, woff_d;
  logic [31:0]       link_q, link_d;
  logic              half_q, half_d;
  logic [AW:0]       wcnt_q, wcnt_d;
  logic [SUM_W-1:0]  pay_q, pay_d;
  logic [31:0]       pend_q, pend_d;
  logic              closing_q, closing_d;
  logic              eenc_q, eenc_d;
  logic              eemp_q, eemp_d;
  logic              eovf_q, eovf_d;
  // output registers
  logic              wr_en_d;
  logic [AW-1:0]     wr_addr_d;
  logic [31:0]       wr_data_d;
  logic              done_d;
  logic [AW:0]       len_d;
  logic              oenc_d, oemp_d, oovf_d;

  // encoder results
  logic              enc_new_base;
  logic [WOFF_W-1:0] enc_woff;
  logic [15:0]       enc_pair;
  logic              enc_bad;
  logic              cap_over;

  // write request from the sequencer
  logic              push;
  logic [31:0]       push_word;
  logic              end_now;
  logic              accept;

  dlp_pair_enc #(.OFF_W(OFF_W), .LEN_W(LEN_W)) u_enc (
    .first       (first_q),
    .base        (ent_base),
    .off         (ent_off),
    .len         (ent_len),
    .prev_region (region_q),
    .prev_woff   (woff_q),
    .new_base    (enc_new_base),
    .woff        (enc_woff),
    .pair        (enc_pair),
    .bad         (enc_bad)
  );

  dlp_cap_check #(.DEPTH(DEPTH), .SUM_W(SUM_W)) u_cap (
    .pay_mode (pay_mode),
    .words    (wcnt_q),
    .payload  (pay_q),
    .over     (cap_over)
  );

  assign ent_ready = (state_q == S_ACC) || (state_q == S_DRAIN);
  assign accept    = ent_valid && ent_ready;

  always_comb begin
    state_d   = state_q;
    first_d   = first_q;
    region_d  = region_q;
    woff_d    = woff_q;
    link_d    = link_q;
    half_d    = half_q;
    wcnt_d    = wcnt_q;
    pay_d     = pay_q;
    pend_d    = pend_q;
    closing_d = closing_q;
    eenc_d    = eenc_q;
    eemp_d    = eemp_q;
    eovf_d    = eovf_q;
    wr_en_d   = 1'b0;
    wr_addr_d = wr_addr;
    wr_data_d = wr_data;
    done_d    = 1'b0;
    len_d     = list_words;
    oenc_d    = err_encode;
    oemp_d    = err_empty;
    oovf_d    = err_overflow;
    push      = 1'b0;
    push_word = '0;
    end_now   = closing_q;

    unique case (state_q)
      S_ACC: begin
        end_now = ent_last;
        if (ent_valid) begin
          closing_d = ent_last;
          if (ent_len == '0) begin
            // no entry carried; only a last beat matters
            if (ent_last) state_d = S_END;
          end else if (enc_bad) begin
            eenc_d  = 1'b1;
            state_d = ent_last ? S_FIN : S_DRAIN;
          end else begin
            pay_d    = pay_q + SUM_W'(ent_len);
            woff_d   = enc_woff;
            region_d = ent_base[31:4];
            first_d  = 1'b0;
            state_d  = ent_last ? S_END : S_ACC;
            if (enc_new_base) begin
              link_d = {LINK_PRESET, enc_pair};
              half_d = 1'b1;
              push   = 1'b1;
              if (half_q) begin
                push_word = link_q;
                pend_d    = make_base_word(ent_base[31:4]);
                state_d   = S_SEC;
              end else begin
                push_word = make_base_word(ent_base[31:4]);
              end
            end else if (half_q) begin
              push      = 1'b1;
              push_word = {enc_pair, link_q[15:0]};
              half_d    = 1'b0;
            end else begin
              link_d = {LINK_PRESET, enc_pair};
              half_d = 1'b1;
            end
          end
        end
      end
      S_SEC: begin
        push      = 1'b1;
        push_word = pend_q;
        state_d   = closing_q ? S_END : S_ACC;
      end
      S_END: begin
        if (first_q) begin
          eemp_d  = 1'b1;
          state_d = S_FIN;
        end else if (half_q) begin
          push      = 1'b1;
          push_word = link_q;
          half_d    = 1'b0;
          state_d   = S_TERM;
        end else begin
          push      = 1'b1;
          push_word = '0;
          state_d   = S_FIN;
        end
      end
      S_TERM: begin
        push      = 1'b1;
        push_word = '0;
        state_d   = S_FIN;
      end
      S_DRAIN: begin
        if (ent_valid && ent_last) state_d = S_FIN;
      end
      S_FIN: begin
        done_d    = 1'b1;
        oenc_d    = eenc_q;
        oemp_d    = eemp_q;
        oovf_d    = eovf_q || (!eenc_q && !eemp_q && cap_over);
        len_d     = (eenc_q || eemp_q || eovf_q || cap_over) ? '0 : wcnt_q;
        first_d   = 1'b1;
        region_d  = '0;
        woff_d    = '0;
        half_d    = 1'b0;
        wcnt_d    = '0;
        pay_d     = '0;
        closing_d = 1'b0;
        eenc_d    = 1'b0;
        eemp_d    = 1'b0;
        eovf_d    = 1'b0;
        state_d   = S_ACC;
      end
      default: state_d = S_ACC;
    endcase

    // single write port with a capacity guard
    if (push) begin
      if (wcnt_q == (AW+1)'(DEPTH)) begin
        eovf_d  = 1'b1;
        state_d = end_now ? S_FIN : S_DRAIN;
      end else begin
        wr_en_d   = 1'b1;
        wr_addr_d = wcnt_q[AW-1:0];
        wr_data_d = push_word;
        wcnt_d    = wcnt_q + (AW+1)'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= S_ACC;
      first_q      <= 1'b1;
      region_q     <= '0;
      woff_q       <= '0;
      link_q       <= '0;
      half_q       <= 1'b0;
      wcnt_q       <= '0;
      pay_q        <= '0;
      pend_q       <= '0;
      closing_q    <= 1'b0;
      eenc_q       <= 1'b0;
      eemp_q       <= 1'b0;
      eovf_q       <= 1'b0;
      wr_en        <= 1'b0;
      wr_addr      <= '0;
      wr_data      <= '0;
      done         <= 1'b0;
      list_words   <= '0;
      err_encode   <= 1'b0;
      err_empty    <= 1'b0;
      err_overflow <= 1'b0;
    end else begin
      state_q      <= state_d;
      first_q      <= first_d;
      region_q     <= region_d;
      woff_q       <= woff_d;
      link_q       <= link_d;
      half_q       <= half_d;
      wcnt_q       <= wcnt_d;
      pay_q        <= pay_d;
      pend_q       <= pend_d;
      closing_q    <= closing_d;
      eenc_q       <= eenc_d;
      eemp_q       <= eemp_d;
      eovf_q       <= eovf_d;
      wr_en        <= wr_en_d;
      wr_addr      <= wr_addr_d;
      wr_data      <= wr_data_d;
      done         <= done_d;
      list_words   <= len_d;
      err_encode   <= oenc_d;
      err_empty    <= oemp_d;
      err_overflow <= oovf_d;
    end
  end

  // consecutive writes belong to one list and step by one word
  assert_seq_addr_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + AW'(1)));

  // a successful list ends with the zero terminator just before done
  assert_term_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && list_words != '0) |-> ($past(wr_en) && $past(wr_data) == 32'h0));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_fail_len_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (err_encode || err_empty || err_overflow)) |-> (list_words == '0));

  assert_drain_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DRAIN) |=> !wr_en);

  assert_ready_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ent_len == '0 && !ent_last) |=> !wr_en);

endmodule

// File: tb/tb_desc_list_packer.sv
module tb_desc_list_packer;
  localparam int SRAM_BYTES = 32;
  localparam int OFF_W = 16;
  localparam int LEN_W = 8;
  localparam int AW = 3;
  localparam int NL = 14;
  localparam int NE = 31;
  localparam int NX = 45;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pay_mode = 1'b0;
  logic ent_valid = 1'b0;
  logic ent_last = 1'b0;
  logic [31:0] ent_base = '0;
  logic [OFF_W-1:0] ent_off = '0;
  logic [LEN_W-1:0] ent_len = '0;
  logic ent_ready, wr_en, done, err_encode, err_empty, err_overflow;
  logic [AW-1:0] wr_addr;
  logic [31:0] wr_data;
  logic [AW:0] list_words;

  always #2 clk = ~clk;

  desc_list_packer #(.SRAM_BYTES(SRAM_BYTES), .OFF_W(OFF_W), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .pay_mode(pay_mode),
    .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_last(ent_last),
    .ent_base(ent_base), .ent_off(ent_off), .ent_len(ent_len),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .list_words(list_words),
    .err_encode(err_encode), .err_empty(err_empty), .err_overflow(err_overflow)
  );

  // beat: {last, base, byte offset, length}
  localparam logic [56:0] ENT [NE] = '{
    {1'b0, 32'h10000000, 16'h0010, 8'd2}, {1'b1, 32'h10000000, 16'h0020, 8'd3},
    {1'b0, 32'h20000000, 16'h0040, 8'd1}, {1'b1, 32'h20000000, 16'h0008, 8'd1},
    {1'b0, 32'h30000010, 16'h0000, 8'd1}, {1'b1, 32'h30000020, 16'h0004, 8'd127},
    {1'b0, 32'h00000000, 16'h0000, 8'd1}, {1'b1, 32'h00000000, 16'h0004, 8'd128},
    {1'b1, 32'h00000000, 16'h0400, 8'd1},
    {1'b1, 32'h00000000, 16'h03FC, 8'd127},
    {1'b1, 32'h00000000, 16'h0000, 8'd0},
    {1'b0, 32'h00000000, 16'h0000, 8'd0}, {1'b1, 32'h00000010, 16'h0008, 8'd1},
    {1'b0, 32'h00000000, 16'h0400, 8'd1}, {1'b0, 32'h00000000, 16'h0000, 8'd1},
    {1'b1, 32'h00000000, 16'h0000, 8'd1},
    {1'b0, 32'h00000010, 16'h0000, 8'd1}, {1'b0, 32'h00000020, 16'h0000, 8'd1},
    {1'b0, 32'h00000030, 16'h0000, 8'd1}, {1'b1, 32'h00000040, 16'h0000, 8'd1},
    {1'b0, 32'h00000010, 16'h0000, 8'd1}, {1'b0, 32'h00000020, 16'h0000, 8'd1},
    {1'b0, 32'h00000030, 16'h0000, 8'd1}, {1'b0, 32'h00000030, 16'h0004, 8'd1},
    {1'b1, 32'h00000030, 16'h0008, 8'd1},
    {1'b0, 32'h10000000, 16'h0010, 8'd2}, {1'b1, 32'h10000000, 16'h0020, 8'd4},
    {1'b0, 32'h10000000, 16'h0010, 8'd2}, {1'b1, 32'h10000000, 16'h0020, 8'd4},
    {1'b0, 32'h10000000, 16'h0010, 8'd2}, {1'b1, 32'h10000000, 16'h0020, 8'd3}
  };

  // result: {pay_mode, writes, list_words, enc, empty, overflow}
  localparam logic [11:0] RES [NL] = '{
    {1'b0, 4'd3, 4'd3, 3'b000}, {1'b0, 4'd5, 4'd5, 3'b000},
    {1'b0, 4'd5, 4'd5, 3'b000}, {1'b0, 4'd1, 4'd0, 3'b100},
    {1'b0, 4'd0, 4'd0, 3'b100}, {1'b0, 4'd3, 4'd3, 3'b000},
    {1'b0, 4'd0, 4'd0, 3'b010}, {1'b0, 4'd3, 4'd3, 3'b000},
    {1'b0, 4'd0, 4'd0, 3'b100}, {1'b0, 4'd8, 4'd0, 3'b001},
    {1'b0, 4'd8, 4'd8, 3'b000}, {1'b1, 4'd3, 4'd0, 3'b001},
    {1'b0, 4'd3, 4'd3, 3'b000}, {1'b1, 4'd3, 4'd3, 3'b000}
  };

  localparam logic [31:0] EXPW [NX] = '{
    32'h81000000, 32'h03040204, 32'h00000000,
    32'h82000000, 32'h00010110, 32'h82000000, 32'h00010102, 32'h00000000,
    32'h83000001, 32'h00010100, 32'h83000002, 32'h00017F01, 32'h00000000,
    32'h80000000,
    32'h80000000, 32'h00017FFF, 32'h00000000,
    32'h80000001, 32'h00010102, 32'h00000000,
    32'h80000001, 32'h00010100, 32'h80000002, 32'h00010100,
    32'h80000003, 32'h00010100, 32'h80000004, 32'h00010100,
    32'h80000001, 32'h00010100, 32'h80000002, 32'h00010100,
    32'h80000003, 32'h01010100, 32'h00010101, 32'h00000000,
    32'h81000000, 32'h04040204, 32'h00000000,
    32'h81000000, 32'h04040204, 32'h00000000,
    32'h81000000, 32'h03040204, 32'h00000000
  };

  int checks = 0;
  int errors = 0;
  int cap_cnt = 0;
  logic [31:0] cap_data [16];
  logic [AW-1:0] cap_addr [16];
  logic got_done = 1'b0;
  logic [AW:0] got_len = '0;
  logic [2:0] got_err = '0;

  always @(negedge clk) begin
    if (wr_en && cap_cnt < 16) begin
      cap_data[cap_cnt] = wr_data;
      cap_addr[cap_cnt] = wr_addr;
      cap_cnt = cap_cnt + 1;
    end
    if (done) begin
      got_done = 1'b1;
      got_len  = list_words;
      got_err  = {err_encode, err_empty, err_overflow};
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic string tag(input int li);
    case (li)
      0: return "R1 R2 R4";
      1: return "R3";
      2: return "R1 R2";
      3: return "R5";
      4: return "R5";
      5: return "R2 R5";
      6: return "R6";
      7: return "R10";
      8: return "R11";
      9: return "R7";
      10: return "R7 R9";
      11: return "R8";
      12: return "R8";
      default: return "R8 R9";
    endcase
  endfunction

  task automatic send(input logic [56:0] e);
    ent_valid = 1'b1;
    ent_last  = e[56];
    ent_base  = e[55:24];
    ent_off   = e[23:8];
    ent_len   = e[7:0];
    while (!ent_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_list(input int li, input int ei, input int xi, output int ei_next);
    int e;
    logic [11:0] r;
    int nw;
    r = RES[li];
    nw = int'(r[10:7]);
    pay_mode = r[11];
    cap_cnt = 0;
    got_done = 1'b0;
    e = ei;
    forever begin
      send(ENT[e]);
      e = e + 1;
      if (ENT[e-1][56]) break;
    end
    ent_valid = 1'b0;
    ent_last = 1'b0;
    for (int k = 0; k < 60 && !got_done; k++) @(negedge clk);
    chk(got_done == 1'b1, "R9", $sformatf("list %0d done seen", li), got_done, 1);
    chk(cap_cnt == nw, tag(li), $sformatf("list %0d write count", li), cap_cnt, nw);
    for (int k = 0; k < nw && k < cap_cnt; k++) begin
      chk(cap_data[k] == EXPW[xi+k], tag(li), $sformatf("list %0d word %0d", li, k),
          cap_data[k], EXPW[xi+k]);
      chk(cap_addr[k] == AW'(k), "R12", $sformatf("list %0d address %0d", li, k),
          cap_addr[k], k);
    end
    chk(got_len == r[6:3], tag(li), $sformatf("list %0d list_words", li), got_len, r[6:3]);
    chk(got_err == r[2:0], tag(li), $sformatf("list %0d error flags", li), got_err, r[2:0]);
    @(negedge clk);
    chk(done == 1'b0, "R9", $sformatf("list %0d done single cycle", li), done, 0);
    ei_next = e;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ei;
    int xi;
    int nxt;
    repeat (3) @(negedge clk);
    chk(wr_en == 1'b0, "R9", "reset wr_en", wr_en, 0);
    chk(done == 1'b0, "R9", "reset done", done, 0);
    chk(list_words == '0, "R9", "reset list_words", list_words, 0);
    chk({err_encode, err_empty, err_overflow} == 3'b000, "R5", "reset errors",
        {err_encode, err_empty, err_overflow}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ent_ready == 1'b1, "R10", "ready after reset", ent_ready, 1);

    ei = 0;
    xi = 0;
    for (int li = 0; li < NL; li++) begin
      run_list(li, ei, xi, nxt);
      ei = nxt;
      xi = xi + int'(RES[li][10:7]);
    end

    // R12: reset in the middle of a list, then a fresh list starts at word 0
    pay_mode = 1'b0;
    send(ENT[2]);
    ent_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(wr_en == 1'b0 && done == 1'b0, "R12", "outputs quiet in reset", {wr_en, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_list(0, 0, 0, nxt);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule